// File: doc/BRIEF.md
# Capture Gating and Output Steering Control

This block holds the 16-bit control word of one capture/compare channel, together with the small amount of timing logic that the word drives. It picks one of six capture sources and drives it to the capture logic: a dedicated input pin, three comparator outputs or two logic-cell outputs. It passes or blocks capture events according to a separate gating input, in one of three gating modes. Two of these modes are one-shot edge modes, and they work through a sticky capture-disable flag.

The same word holds six output-steering enables, which decide whether the channel or other logic owns each output. A write either applies the new enables on the next clock, or parks them until the time base next rolls over or is reset. A newer parked write replaces an older one. An auxiliary output sends out one chosen event source: time base rollovers, a signal defined by the operating mode, or capture and compare events.

Control word layout (bit positions): bit 15 is the enable-sync flag, bits 13:8 are the six output enables, bits 7:6 are the gating mode, bits 4:3 are the auxiliary select and bits 2:0 are the capture source select. Bits 14 and 5 are unused.

Top module: `capsteer_top`

## Requirements
- R1: After reset, rd_data reads 16'h0100, oe_out is 6'b000001, aux_out is 0 and cap_dis is 0.
- R2: A write of wr_data shows on rd_data from the following cycle, with bits 14 and 5 forced to zero.
- R3: The source select field (bits 2:0) with value k from 0 to 5 drives cap_src_out with src_in[k]. Index 0 is the pin, 1 to 3 are the comparators and 4 to 5 are the logic cells. Values 6 and 7 drive cap_src_out to 0 and block cap_evt_out.
- R4: In gating mode 00 (bits 7:6), cap_evt_out equals cap_evt_in in the same cycle while gate_in is high, and is 0 while gate_in is low.
- R5: In gating mode 01, a rising edge of gate_in clears cap_dis from the next cycle. A falling edge leaves cap_dis unchanged. In both one-shot modes, capture events pass exactly when cap_dis is 0.
- R6: In gating mode 10, a falling edge of gate_in sets cap_dis from the next cycle. After that, capture events are blocked.
- R7: Gating mode 11 blocks all capture events. Modes 00 and 11 leave cap_dis unchanged.
- R8: A write with bit 15 at 0 drives oe_out with wr_data[13:8] from the next cycle.
- R9: A write with bit 15 at 1 leaves oe_out unchanged until a cycle with tb_roll or tb_rst high. From the following cycle, oe_out holds the most recent such parked value. A boundary with nothing parked changes nothing.
- R10: With auxiliary select 00 (bits 4:3), aux_out stays 0. With select 01, aux_out is high for one cycle, one cycle after each tb_roll pulse.
- R11: With auxiliary select 10, aux_out follows mode_sig_in delayed by one cycle.
- R12: With auxiliary select 11, aux_out pulses one cycle after a gated capture event (cap_evt_out) or a cmp_evt_in pulse. It stays 0 while timer_mode is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Control word readback |
| src_in | input | 6 | Capture source candidates |
| gate_in | input | 1 | Capture gating input |
| cap_evt_in | input | 1 | Raw capture event |
| cmp_evt_in | input | 1 | Compare event |
| tb_roll | input | 1 | Time base rollover strobe |
| tb_rst | input | 1 | Time base reset strobe |
| timer_mode | input | 1 | Channel is in timer mode |
| mode_sig_in | input | 1 | Mode-defined auxiliary signal |
| cap_src_out | output | 1 | Selected capture source |
| cap_evt_out | output | 1 | Gated capture event |
| cap_dis | output | 1 | Sticky capture-disable flag |
| oe_out | output | 6 | Effective output-steering enables |
| aux_out | output | 1 | Auxiliary event output |

## Verification
A wrong disable flag shows on cap_dis one cycle after the gating edge that should have moved it. It also shows as a blocked or leaked event on cap_evt_out, and on aux_out one cycle later. A wrong parked enable value, or a lost valid bit, stays hidden until the next time base boundary, and then shows on oe_out in the cycle after it. For that reason the bench writes several times, and makes several boundaries with and without a parked value.

// File: rtl/capsteer_pkg.sv
package capsteer_pkg;
  localparam int REG_W    = 16;
  localparam int SYNC_BIT = 15;
  localparam int OE_LSB   = 8;
  localparam int OE_N     = 6;
  localparam int GM_LSB   = 6;
  localparam int AUX_LSB  = 3;
  localparam int SRC_LSB  = 0;
  localparam int SRC_W    = 3;
  localparam int N_SRC    = 6;
  localparam int UNUSED_A = 14;
  localparam int UNUSED_B = 5;

  typedef enum logic [1:0] {
    GM_LEVEL  = 2'b00,
    GM_ARM    = 2'b01,
    GM_DISARM = 2'b10,
    GM_RSVD   = 2'b11
  } gate_mode_e;

  typedef enum logic [1:0] {
    AX_OFF  = 2'b00,
    AX_ROLL = 2'b01,
    AX_MODE = 2'b10,
    AX_EVT  = 2'b11
  } aux_sel_e;
endpackage

// File: rtl/capsteer_regs.sv
module capsteer_regs
  import capsteer_pkg::*;
#(
  parameter int W      = REG_W,
  parameter int NOE    = OE_N,
  parameter int OE_POS = OE_LSB,
  parameter int SY_POS = SYNC_BIT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_data,
  input  logic           tb_bound,
  output logic [W-1:0]   rd_data,
  output logic [NOE-1:0] oe_act
);
  localparam logic [W-1:0] WR_MASK = ~((W'(1) << UNUSED_A) | (W'(1) << UNUSED_B));
  localparam logic [W-1:0] RST_VAL = W'(1) << OE_POS;
  localparam logic [NOE-1:0] OE_RST = NOE'(1);

  logic [W-1:0]   reg_q, reg_d;
  logic [NOE-1:0] oe_q, oe_d;
  logic [NOE-1:0] pend_q, pend_d;
  logic           pv_q, pv_d;
  logic           wr_now, wr_park;

  assign wr_now  = wr_en && !wr_data[SY_POS];
  assign wr_park = wr_en &&  wr_data[SY_POS];

  always_comb begin
    reg_d  = reg_q;
    oe_d   = oe_q;
    pend_d = pend_q;
    pv_d   = pv_q;
    if (wr_en) begin
      reg_d = wr_data & WR_MASK;
    end
    if (wr_now) begin
      oe_d = wr_data[OE_POS +: NOE];
      pv_d = 1'b0;
    end else if (wr_park) begin
      pend_d = wr_data[OE_POS +: NOE];
      pv_d   = 1'b1;
    end else if (tb_bound && pv_q) begin
      oe_d = pend_q;
      pv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= RST_VAL;
      oe_q   <= OE_RST;
      pend_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      reg_q  <= reg_d;
      oe_q   <= oe_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
    end
  end

  assign rd_data = reg_q;
  assign oe_act  = oe_q;

  // R2: readback follows the write with unused bits cleared
  p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == ($past(wr_data) & WR_MASK)));

  // R8: immediate enables appear on the next cycle
  p_oe_immediate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> (oe_act == $past(wr_data[OE_POS +: NOE])));

  // R9: without an immediate write or a boundary the enables hold
  p_oe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_now && !tb_bound) |=> $stable(oe_act));
endmodule

// File: rtl/capsteer_gate.sv
module capsteer_gate
  import capsteer_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int SW = SRC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] src_sel,
  input  gate_mode_e    gmode,
  input  logic [NS-1:0] src_in,
  input  logic          gate_in,
  input  logic          cap_evt_in,
  output logic          cap_src_out,
  output logic          cap_evt_out,
  output logic          cap_dis
);
  logic [NS-1:0] hit;
  logic          src_ok;
  logic          gate_q, gate_d;
  logic          dis_q, dis_d;
  logic          rise, fall;
  logic          allow;

  for (genvar g = 0; g < NS; g++) begin : g_src
    assign hit[g] = (src_sel == SW'(g)) && src_in[g];
  end

  assign src_ok      = (int'(src_sel) < NS);
  assign cap_src_out = |hit;

  assign rise = gate_in && !gate_q;
  assign fall = !gate_in && gate_q;

  always_comb begin
    gate_d = gate_in;
    dis_d  = dis_q;
    allow  = 1'b0;
    unique case (gmode)
      GM_LEVEL:  allow = gate_in;
      GM_ARM: begin
        allow = !dis_q;
        if (rise) dis_d = 1'b0;
      end
      GM_DISARM: begin
        allow = !dis_q;
        if (fall) dis_d = 1'b1;
      end
      default:   allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      gate_q <= gate_d;
      dis_q  <= dis_d;
    end
  end

  assign cap_evt_out = cap_evt_in && allow && src_ok;
  assign cap_dis     = dis_q;

  // R3: reserved source codes block source and events
  p_src_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !src_ok |-> (!cap_src_out && !cap_evt_out));

  // R4: level mode with the gate low blocks events
  p_level_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gmode == GM_LEVEL && !gate_in) |-> !cap_evt_out);

  // R5: arming edge clears the flag
  p_arm_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gmode == GM_ARM && gate_in && !gate_q) |=> !cap_dis);

  // R6: disarming edge sets the flag
  p_disarm_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gmode == GM_DISARM && !gate_in && gate_q) |=> cap_dis);

  // R7: reserved gating mode blocks and holds the flag
  p_rsvd_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gmode == GM_RSVD) |-> !cap_evt_out);
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gmode == GM_LEVEL || gmode == GM_RSVD) |=> $stable(cap_dis));
endmodule

// File: rtl/capsteer_aux.sv
module capsteer_aux
  import capsteer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  aux_sel_e aux_sel,
  input  logic     tb_roll,
  input  logic     mode_sig_in,
  input  logic     cap_evt,
  input  logic     cmp_evt_in,
  input  logic     timer_mode,
  output logic     aux_out
);
  logic aux_q, aux_d;

  always_comb begin
    unique case (aux_sel)
      AX_OFF:  aux_d = 1'b0;
      AX_ROLL: aux_d = tb_roll;
      AX_MODE: aux_d = mode_sig_in;
      default: aux_d = (cap_evt || cmp_evt_in) && !timer_mode;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aux_q <= 1'b0;
    else        aux_q <= aux_d;
  end

  assign aux_out = aux_q;

  // R10: disabled selection keeps the output low
  p_aux_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_sel == AX_OFF) |=> !aux_out);

  // R11: mode selection follows the mode signal one cycle later
  p_aux_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_sel == AX_MODE) |=> (aux_out == $past(mode_sig_in)));

  // R12: event selection is silent in timer mode
  p_aux_timer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_sel == AX_EVT && timer_mode) |=> !aux_out);
endmodule

// File: rtl/capsteer_top.sv
module capsteer_top
  import capsteer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [N_SRC-1:0] src_in,
  input  logic             gate_in,
  input  logic             cap_evt_in,
  input  logic             cmp_evt_in,
  input  logic             tb_roll,
  input  logic             tb_rst,
  input  logic             timer_mode,
  input  logic             mode_sig_in,
  output logic             cap_src_out,
  output logic             cap_evt_out,
  output logic             cap_dis,
  output logic [OE_N-1:0]  oe_out,
  output logic             aux_out
);
  logic [REG_W-1:0] ctrl;
  logic             evt_gated;
  gate_mode_e       gmode;
  aux_sel_e         asel;

  capsteer_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .tb_bound (tb_roll || tb_rst),
    .rd_data  (ctrl),
    .oe_act   (oe_out)
  );

  assign gmode   = gate_mode_e'(ctrl[GM_LSB +: 2]);
  assign asel    = aux_sel_e'(ctrl[AUX_LSB +: 2]);
  assign rd_data = ctrl;

  capsteer_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_sel     (ctrl[SRC_LSB +: SRC_W]),
    .gmode       (gmode),
    .src_in      (src_in),
    .gate_in     (gate_in),
    .cap_evt_in  (cap_evt_in),
    .cap_src_out (cap_src_out),
    .cap_evt_out (evt_gated),
    .cap_dis     (cap_dis)
  );

  assign cap_evt_out = evt_gated;

  capsteer_aux u_aux (
    .clk         (clk),
    .rst_n       (rst_n),
    .aux_sel     (asel),
    .tb_roll     (tb_roll),
    .mode_sig_in (mode_sig_in),
    .cap_evt     (evt_gated),
    .cmp_evt_in  (cmp_evt_in),
    .timer_mode  (timer_mode),
    .aux_out     (aux_out)
  );
endmodule

// File: tb/capsteer_top_tb_top.sv
module capsteer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [5:0]  src_in = '0;
  logic        gate_in = 1'b0, cap_evt_in = 1'b0, cmp_evt_in = 1'b0;
  logic        tb_roll = 1'b0, tb_rst = 1'b0, timer_mode = 1'b0, mode_sig_in = 1'b0;
  logic        cap_src_out, cap_evt_out, cap_dis, aux_out;
  logic [5:0]  oe_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  capsteer_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .src_in(src_in), .gate_in(gate_in), .cap_evt_in(cap_evt_in), .cmp_evt_in(cmp_evt_in),
    .tb_roll(tb_roll), .tb_rst(tb_rst), .timer_mode(timer_mode), .mode_sig_in(mode_sig_in),
    .cap_src_out(cap_src_out), .cap_evt_out(cap_evt_out), .cap_dis(cap_dis),
    .oe_out(oe_out), .aux_out(aux_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 16'h0100);
    chk("R1 oe_out", 16'(oe_out), 16'h0001);
    chk("R1 aux_out", 16'(aux_out), 16'h0);
    chk("R1 cap_dis", 16'(cap_dis), 16'h0);
  endtask

  task automatic t_readback();
    wr(16'hFFFF);
    chk("R2 mask", rd_data, 16'hBFDF);
    wr(16'h1234);
    chk("R2 value", rd_data, 16'h1214);
  endtask

  task automatic t_source();
    gate_in = 1'b1; cap_evt_in = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wr(16'(k));
      src_in = 6'(1 << k); #1;
      chk("R3 selected high", 16'(cap_src_out), 16'h1);
      chk("R3 event pass", 16'(cap_evt_out), 16'h1);
      src_in = ~6'(1 << k); #1;
      chk("R3 selected low", 16'(cap_src_out), 16'h0);
    end
    for (int k = 6; k < 8; k++) begin
      wr(16'(k));
      src_in = 6'h3F; #1;
      chk("R3 reserved source", 16'(cap_src_out), 16'h0);
      chk("R3 reserved event", 16'(cap_evt_out), 16'h0);
    end
    cap_evt_in = 1'b0; src_in = '0;
  endtask

  task automatic t_level();
    wr(16'h0000);
    gate_in = 1'b1; cap_evt_in = 1'b1; #1;
    chk("R4 gate high", 16'(cap_evt_out), 16'h1);
    gate_in = 1'b0; #1;
    chk("R4 gate low", 16'(cap_evt_out), 16'h0);
    cap_evt_in = 1'b0; #1;
    gate_in = 1'b1; #1;
    chk("R4 no raw event", 16'(cap_evt_out), 16'h0);
    cyc(1);
  endtask

  task automatic t_oneshot();
    wr(16'h0080);                       // disarm mode, gate high from level test
    cap_evt_in = 1'b1; #1;
    chk("R6 pass before edge", 16'(cap_evt_out), 16'h1);
    @(negedge clk); gate_in = 1'b0;
    @(negedge clk);
    chk("R6 flag set", 16'(cap_dis), 16'h1);
    chk("R6 blocked", 16'(cap_evt_out), 16'h0);
    wr(16'h0000);                       // level mode holds flag
    @(negedge clk); gate_in = 1'b1;
    @(negedge clk);
    chk("R7 level holds flag", 16'(cap_dis), 16'h1);
    chk("R4 level ignores flag", 16'(cap_evt_out), 16'h1);
    @(negedge clk); gate_in = 1'b0;
    wr(16'h0040);                       // arm mode
    chk("R5 blocked before edge", 16'(cap_evt_out), 16'h0);
    @(negedge clk); gate_in = 1'b1;
    @(negedge clk);
    chk("R5 flag cleared", 16'(cap_dis), 16'h0);
    chk("R5 pass", 16'(cap_evt_out), 16'h1);
    @(negedge clk); gate_in = 1'b0;
    @(negedge clk);
    chk("R5 fall ignored", 16'(cap_dis), 16'h0);
    wr(16'h00C0);                       // reserved mode
    #1;
    chk("R7 reserved blocks", 16'(cap_evt_out), 16'h0);
    @(negedge clk); gate_in = 1'b1;
    @(negedge clk); gate_in = 1'b0;
    @(negedge clk);
    chk("R7 reserved holds flag", 16'(cap_dis), 16'h0);
    cap_evt_in = 1'b0;
  endtask

  task automatic t_oe();
    wr(16'h2A00);
    chk("R8 immediate", 16'(oe_out), 16'h002A);
    wr(16'h9500);
    cyc(3);
    chk("R9 parked hold", 16'(oe_out), 16'h002A);
    wr(16'h8C00);
    chk("R9 newer parked hold", 16'(oe_out), 16'h002A);
    @(negedge clk); tb_roll = 1'b1;
    @(negedge clk); tb_roll = 1'b0;
    chk("R9 rollover applies newest", 16'(oe_out), 16'h000C);
    @(negedge clk); tb_roll = 1'b1;
    @(negedge clk); tb_roll = 1'b0;
    chk("R9 empty boundary", 16'(oe_out), 16'h000C);
    wr(16'hB300);
    @(negedge clk); tb_rst = 1'b1;
    @(negedge clk); tb_rst = 1'b0;
    chk("R9 reset strobe applies", 16'(oe_out), 16'h0033);
  endtask

  task automatic t_aux();
    wr(16'h0008);
    @(negedge clk); tb_roll = 1'b1;
    @(negedge clk); tb_roll = 1'b0;
    chk("R10 roll pulse", 16'(aux_out), 16'h1);
    @(negedge clk);
    chk("R10 pulse width", 16'(aux_out), 16'h0);
    wr(16'h0000);
    @(negedge clk); tb_roll = 1'b1; mode_sig_in = 1'b1; cmp_evt_in = 1'b1;
    @(negedge clk); tb_roll = 1'b0; mode_sig_in = 1'b0; cmp_evt_in = 1'b0;
    chk("R10 off", 16'(aux_out), 16'h0);
    wr(16'h0010);
    @(negedge clk); mode_sig_in = 1'b1;
    @(negedge clk);
    chk("R11 follow high", 16'(aux_out), 16'h1);
    mode_sig_in = 1'b0;
    @(negedge clk);
    chk("R11 follow low", 16'(aux_out), 16'h0);
    wr(16'h0018);                        // event select, level gate, pin source
    gate_in = 1'b1;
    @(negedge clk); cmp_evt_in = 1'b1;
    @(negedge clk); cmp_evt_in = 1'b0;
    chk("R12 compare pulse", 16'(aux_out), 16'h1);
    @(negedge clk); cap_evt_in = 1'b1;
    @(negedge clk); cap_evt_in = 1'b0;
    chk("R12 capture pulse", 16'(aux_out), 16'h1);
    @(negedge clk); gate_in = 1'b0; cap_evt_in = 1'b1;
    @(negedge clk); cap_evt_in = 1'b0;
    chk("R12 gated capture silent", 16'(aux_out), 16'h0);
    timer_mode = 1'b1;
    @(negedge clk); cmp_evt_in = 1'b1;
    @(negedge clk); cmp_evt_in = 1'b0;
    chk("R12 timer mode silent", 16'(aux_out), 16'h0);
    timer_mode = 1'b0;
  endtask

  initial begin
    cyc(3);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_source();
    t_level();
    t_oneshot();
    t_oe();
    t_aux();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule